// File: doc/BRIEF.md
# Serial Receiver with Request-to-Send Flow Control

This block receives asynchronous serial frames of eight data bits, no parity and one stop bit, least significant bit first. The line is sampled on an oversampling tick that runs at sixteen times the baud rate. A start bit is accepted only if the line is still low at its middle. Received bytes go either into a single holding register or into a receive FIFO, depending on a mode input. A consumer reads them through a show-ahead port: the head byte is always visible, and a one-cycle read request removes it.

The active-low request-to-send output tells the remote transmitter whether another byte can be accepted. In single-register mode it goes inactive as soon as an unread byte is held. In FIFO mode it goes inactive only when every FIFO slot is occupied. When flow control is switched off, the output stays inactive. A frame that arrives with no free space is discarded and sets a sticky overrun flag. A frame with a low stop bit is still stored, and its framing-error mark travels with it.

Top module: `serial_rx_flow`

## Requirements
- R1: After reset the buffer is empty: `dataAvail` is 0, `overrun` is 0, and `rtsN` is 0 if `cfgRtsEn` is 1 and 1 if `cfgRtsEn` is 0.
- R2: One oversampling tick occurs every `cfgBaudDiv` clock cycles, and one bit lasts 16 ticks. A frame is a low start bit, eight data bits sent LSB first, and a high stop bit. The received byte appears on `rdData`.
- R3: A low pulse on `rxLine` that ends before the middle of a bit period (under 8 ticks) starts no frame, and nothing is stored.
- R4: `dataAvail` rises at the mid-stop sample of a received frame. A one-cycle `rdReq` with `dataAvail` high removes the head byte on that clock edge.
- R5: With `cfgRtsEn` at 0, `rtsN` is 1 at all times.
- R6: With `cfgRtsEn` at 1 and `cfgFifoEn` at 0, `rtsN` is 1 while one unread byte is held, and it returns to 0 in the cycle after that byte is read.
- R7: With `cfgRtsEn` at 1 and `cfgFifoEn` at 1, `rtsN` stays 0 while fewer than DEPTH bytes are held and goes to 1 when DEPTH bytes are held. Bytes are read out in arrival order.
- R8: A frame that completes while the buffer is full is discarded: the stored bytes and `rdData` are unchanged, and `overrun` becomes 1 and stays 1 until reset.
- R9: A frame whose stop bit samples low is still stored. `frameErr` is 1 while that byte is at the head and 0 for bytes with a good stop bit.
- R10: Reset empties the receive FIFO. Bytes held before reset are gone afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| cfgRtsEn | input | 1 | Enables request-to-send flow control |
| cfgFifoEn | input | 1 | Selects FIFO storage instead of a single register |
| cfgBaudDiv | input | 16 | Clock cycles per oversampling tick |
| rdReq | input | 1 | Read strobe; removes the head byte |
| rdData | output | 8 | Head byte |
| frameErr | output | 1 | Framing-error mark of the head byte |
| dataAvail | output | 1 | At least one byte is held |
| overrun | output | 1 | Sticky: a frame was dropped for lack of space |
| rtsN | output | 1 | Active-low request to send |

## Verification
The bench fills the FIFO to one below its depth and then to its depth. A design that releases request-to-send at the wrong count, or that applies the single-register rule in FIFO mode, shows the wrong `rtsN` level at one of those two points. It sends a frame into a full single register and checks that the held byte survives and `overrun` sticks; a design that overwrites the byte or accepts the frame fails there. It also sends a short low glitch, which a receiver without the mid-bit confirmation would take as a frame, and a frame with a bad stop bit, which a design that drops the byte or marks the wrong byte would mishandle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic shiftBit;   // sample a data bit
    logic bitVal;     // the sampled line value
    logic frameDone;  // stop bit sampled
    logic stopBad;    // stop bit was low
  } rxStrobe_t;
endpackage

// File: rtl/rx_bit_ctrl.sv
module rx_bit_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [DIV_W-1:0] cfgBaudDiv,
  output rxStrobe_t        strb
);
  localparam int TICKS_PER_BIT = 16;
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);
  localparam logic [TW-1:0] MID_TICK = TW'(TICKS_PER_BIT / 2 - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxState_t;

  rxState_t state;
  logic [1:0] rxSync;
  logic rxS;
  logic [DIV_W-1:0] divCnt;
  logic tick;
  logic [TW-1:0] tickCnt;
  logic [2:0] bitIdx;

  assign rxS = rxSync[1];
  assign tick = ({1'b0, divCnt} + 1'b1) >= {1'b0, cfgBaudDiv};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      divCnt <= '0;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: if (!rxS) begin
          state   <= S_START;
          tickCnt <= '0;
        end
        S_START: if (tickCnt == MID_TICK) begin
          state   <= rxS ? S_IDLE : S_DATA;
          tickCnt <= '0;
          bitIdx  <= '0;
        end else tickCnt <= tickCnt + 1'b1;
        S_DATA: if (tickCnt == LAST_TICK) begin
          tickCnt <= '0;
          bitIdx  <= bitIdx + 1'b1;
          if (bitIdx == 3'd7) state <= S_STOP;
        end else tickCnt <= tickCnt + 1'b1;
        default: if (tickCnt == LAST_TICK) state <= S_IDLE;
                 else tickCnt <= tickCnt + 1'b1;
      endcase
    end
  end

  always_comb begin
    strb.shiftBit  = tick && (state == S_DATA) && (tickCnt == LAST_TICK);
    strb.bitVal    = rxS;
    strb.frameDone = tick && (state == S_STOP) && (tickCnt == LAST_TICK);
    strb.stopBad   = !rxS;
  end
endmodule

// File: rtl/rx_store.sv
module rx_store
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strb,
  input  logic       cfgRtsEn,
  input  logic       cfgFifoEn,
  input  logic       rdReq,
  output logic [7:0] rdData,
  output logic       frameErr,
  output logic       dataAvail,
  output logic       overrun,
  output logic       rtsN
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0] shReg;
  logic [8:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic full, push, pop;

  assign full = cfgFifoEn ? (count == FULL_CNT) : (count != '0);
  assign push = strb.frameDone && !full;
  assign pop  = rdReq && (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else if (strb.shiftBit) shReg <= {strb.bitVal, shReg[7:1]};
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (push && (wrPtr == PTR_W'(i))) mem[i] <= {strb.stopBad, shReg};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (strb.frameDone && full) overrun <= 1'b1;
    end
  end

  assign rdData    = mem[rdPtr][7:0];
  assign frameErr  = dataAvail && mem[rdPtr][8];
  assign dataAvail = (count != '0);
  assign rtsN      = !cfgRtsEn || full;
endmodule

// File: rtl/serial_rx_flow.sv
module serial_rx_flow
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             cfgRtsEn,
  input  logic             cfgFifoEn,
  input  logic [DIV_W-1:0] cfgBaudDiv,
  input  logic             rdReq,
  output logic [7:0]       rdData,
  output logic             frameErr,
  output logic             dataAvail,
  output logic             overrun,
  output logic             rtsN
);
  rxStrobe_t strb;

  rx_bit_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cfgBaudDiv(cfgBaudDiv), .strb(strb)
  );

  rx_store #(.DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgRtsEn(cfgRtsEn), .cfgFifoEn(cfgFifoEn),
    .rdReq(rdReq), .rdData(rdData), .frameErr(frameErr), .dataAvail(dataAvail),
    .overrun(overrun), .rtsN(rtsN)
  );
endmodule

// File: rtl/serial_rx_flow_chk.sv
module serial_rx_flow_chk #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxLine,
  input logic             cfgRtsEn,
  input logic             cfgFifoEn,
  input logic [DIV_W-1:0] cfgBaudDiv,
  input logic             rdReq,
  input logic [7:0]       rdData,
  input logic             frameErr,
  input logic             dataAvail,
  input logic             overrun,
  input logic             rtsN
);
  AST_RTS_OFF_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRtsEn |-> rtsN); // R5
  AST_SINGLE_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRtsEn && !cfgFifoEn && dataAvail) |-> rtsN); // R6
  AST_FIFO_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRtsEn && cfgFifoEn && !dataAvail) |-> !rtsN); // R7
  AST_AVAIL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && !rdReq) |=> dataAvail); // R4
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && !rdReq) |=> $stable(rdData)); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R8
endmodule

bind serial_rx_flow serial_rx_flow_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) chk (.*);

// File: tb/serial_rx_flow_test.sv
`timescale 1ns/1ps
module serial_rx_flow_test;
  localparam int DEPTH = 8;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 0, rstN = 0, rxLine = 1, cfgRtsEn = 1, cfgFifoEn = 0, rdReq = 0;
  logic [15:0] cfgBaudDiv = 16'(DIV);
  logic [7:0] rdData;
  logic frameErr, dataAvail, overrun, rtsN;
  int checks = 0, errors = 0;
  logic [7:0] exp [$];

  always #4 clk = ~clk;

  serial_rx_flow #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cfgRtsEn(cfgRtsEn), .cfgFifoEn(cfgFifoEn),
    .cfgBaudDiv(cfgBaudDiv), .rdReq(rdReq), .rdData(rdData), .frameErr(frameErr),
    .dataAvail(dataAvail), .overrun(overrun), .rtsN(rtsN)
  );

  function automatic logic expRts(logic en, logic fifo, int held);
    if (!en) return 1'b1;
    return fifo ? (held >= DEPTH) : (held >= 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; rxLine = 1;
    repeat (4) @(negedge clk);
    rstN = 1; exp.delete();
    @(negedge clk);
  endtask

  task automatic sendFrame(logic [7:0] b, logic stopVal);
    @(negedge clk); rxLine = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxLine = stopVal;
    repeat (BIT) @(negedge clk);
    rxLine = 1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic readOne();
    @(negedge clk); rdReq = 1;
    @(negedge clk); rdReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h1234_5EED));
    doReset();
    // R1 reset state
    chk("R1 avail", dataAvail, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rts", rtsN, expRts(1, 0, 0));

    // R2 R4 R6 single-register receive
    sendFrame(8'hA5, 1);
    chk("R2 data", rdData, 8'hA5);
    chk("R4 avail", dataAvail, 1);
    chk("R9 good stop", frameErr, 0);
    chk("R6 rts held", rtsN, expRts(1, 0, 1));
    // R8 overrun while full
    sendFrame(8'h3C, 1);
    chk("R8 overrun", overrun, 1);
    chk("R8 head kept", rdData, 8'hA5);
    readOne();
    chk("R4 popped", dataAvail, 0);
    chk("R6 rts released", rtsN, expRts(1, 0, 0));
    chk("R8 dropped", dataAvail, 0);
    chk("R8 sticky", overrun, 1);

    // R3 glitch of 3 ticks
    @(negedge clk); rxLine = 0;
    repeat (3 * DIV) @(negedge clk);
    rxLine = 1;
    repeat (2 * BIT) @(negedge clk);
    chk("R3 glitch ignored", dataAvail, 0);
    sendFrame(8'h5A, 1);
    chk("R3 next frame", rdData, 8'h5A);
    readOne();

    // R9 framing error still stored
    sendFrame(8'hC3, 0);
    chk("R9 stored", dataAvail, 1);
    chk("R9 data", rdData, 8'hC3);
    chk("R9 flag", frameErr, 1);
    readOne();

    // R5 flow control off
    cfgRtsEn = 0;
    @(negedge clk);
    chk("R5 empty", rtsN, 1);
    sendFrame(8'h11, 1);
    chk("R5 held", rtsN, 1);
    readOne();
    chk("R5 after read", rtsN, 1);

    // R7 FIFO mode
    cfgRtsEn = 1; cfgFifoEn = 1;
    doReset();
    chk("R1 overrun cleared", overrun, 0);
    for (int i = 0; i < DEPTH; i++) begin
      b = 8'($urandom);
      sendFrame(b, 1);
      exp.push_back(b);
      chk("R7 rts level", rtsN, expRts(1, 1, exp.size()));
    end
    chk("R7 no overrun", overrun, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R7 order", rdData, exp.pop_front());
      readOne();
    end
    chk("R7 drained", dataAvail, 0);

    // R10 reset empties FIFO
    sendFrame(8'h77, 1);
    sendFrame(8'h88, 1);
    doReset();
    chk("R10 empty", dataAvail, 0);
    chk("R10 rts", rtsN, 0);

    // random frames in both modes
    for (int k = 0; k < 16; k++) begin
      cfgFifoEn = k[0];
      b = 8'($urandom);
      sendFrame(b, 1);
      chk("R2 random data", rdData, b);
      chk("R6 R7 random rts", rtsN, expRts(1, cfgFifoEn, 1));
      readOne();
      chk("R4 random pop", dataAvail, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule